// File: doc/BRIEF.md
# Segmented Data Memory Address Extender

This block sits between the load/store path of a small 8-bit controller and its 512-byte data RAM. Each access carries an 8-bit data address. The block turns that address into a physical RAM location. Addresses with the top bit clear form a 128-byte window. A memory-mapped segment register moves that window over pages of 128 bytes. Addresses with the top bit set always land in the fixed upper base page, whatever the segment register holds. The top sixteen bytes of that page are registers, and four of them are the pointer registers: X, the stack pointer, B and the segment register itself.

Accesses made relative to the stack pointer carry a flag. A flagged access in the lower window is pinned to segment 0, and it never changes the segment register. Only segments 0 to 3 hold RAM, and segment 0 holds RAM at its lower offsets 0x00 to 0x6F only. An access that lands outside the populated RAM raises an invalid flag and reads back as zero. Upper base addresses from 0x80 to 0xEF belong to I/O and control logic outside this block. This block answers them with zero and does not flag them.

Every access returns read data one cycle later. A write also returns the value the location held before the write.

Top module: `dmx_seg_extender`

## Requirements
- R1: Addresses 0xF0 to 0xFB reach the same sixteen-byte register storage whatever the segment register holds. The stack flag makes no difference to them either.
- R2: A lower-half address (bit 7 = 0) with the segment register at n (0 to 3) reaches physical location n*0x100 + addr[6:0]. Each of the populated segments has storage of its own.
- R3: A lower-half access with the stack flag set goes to segment 0 whatever the segment register holds, and it leaves the segment register unchanged.
- R4: In segment 0, offsets 0x70 to 0x7F hold no RAM. A read there returns 0x00 and raises the invalid flag, and a write there changes no storage.
- R5: With the segment register at 4 or above, a lower-half access without the stack flag returns 0x00 and raises the invalid flag, and a write changes no storage. Offset 0x7F of segment 3 (physical 0x037F) is valid.
- R6: The pointer registers sit at fixed addresses and can be read and written there: X at 0xFC, the stack pointer at 0xFD, B at 0xFE and the segment register at 0xFF.
- R7: Reset is asynchronous and active low, and it is released two clock edges after the reset input rises. After reset, the stack pointer reads 0x6F and X, B and the segment register read 0x00. The read data bus is 0x00 and the invalid flag is low.
- R8: A write to 0xFF changes the segment register at that clock edge. The very next access uses the new segment.
- R9: Read data and the invalid flag appear on the cycle after the access. The invalid flag is high only in the cycle that follows an invalid access.
- R10: Every access returns the content the location held before that access. A write therefore returns the old value, and the new value is returned on a later access.
- R11: Upper base addresses 0x80 to 0xEF read 0x00 with the invalid flag low, and writes to them have no effect here.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Data address from the instruction or a pointer |
| acc_wdata | input | 8 | Data to write |
| acc_stack | input | 1 | Access is relative to the stack pointer |
| rd_data | output | 8 | Prior content of the location accessed one cycle earlier |
| rd_invalid | output | 1 | The access one cycle earlier hit unpopulated memory |

## Verification
The bench builds the block with its default parameters: four populated segments, an 8-bit segment register and a stack pointer reset value of 0x6F. With these values the boundaries are within reach: the last valid byte at 0x037F, the first unpopulated segment at 4, and the folded register window. Segment values up to 255 are also reachable through plain writes to 0xFF. The bench models the address map directly from the requirements, and every access it issues is compared one cycle later. This includes a long pseudo-random run that mixes writes to the segment register and stack-flagged accesses.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  // Where a decoded access lands.
  typedef enum logic [1:0] {
    K_RAM     = 2'd0,  // populated RAM array
    K_PTR     = 2'd1,  // pointer register flops
    K_HOLE    = 2'd2,  // unpopulated: invalid access
    K_FOREIGN = 2'd3   // upper base I/O space, served elsewhere
  } acc_kind_e;

  // Pointer register selects, taken from the low address bits.
  localparam logic [1:0] PSEL_X  = 2'd0;
  localparam logic [1:0] PSEL_SP = 2'd1;
  localparam logic [1:0] PSEL_B  = 2'd2;
  localparam logic [1:0] PSEL_S  = 2'd3;

endpackage

// File: rtl/dmx_decode.sv
module dmx_decode
  import dmx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SEG_W     = 8,
  parameter int POP_SEGS  = 4,
  parameter int BASE_LAST = 'h6F,
  localparam int OFF_W    = ADDR_W - 1,
  localparam int SEL_W    = $clog2(POP_SEGS),
  localparam int IDX_W    = SEL_W + OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              stack,
  input  logic [SEG_W-1:0]  seg,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        ptr_sel
);

  logic [OFF_W-1:0] off;
  logic [SEG_W-1:0] seg_eff;
  logic             upper;
  logic             reg_window;
  logic             ptr_slot;

  always_comb begin
    off        = addr[OFF_W-1:0];
    upper      = addr[ADDR_W-1];
    reg_window = &off[OFF_W-1:4];
    ptr_slot   = &off[3:2];
    // Stack-relative traffic is pinned to the base segment.
    seg_eff    = stack ? '0 : seg;
    ptr_sel    = addr[1:0];
  end

  always_comb begin
    kind = K_FOREIGN;
    idx  = '0;
    if (upper) begin
      if (reg_window) begin
        if (ptr_slot) begin
          kind = K_PTR;
        end else begin
          // General registers fold into the unused tail of segment 0.
          kind = K_RAM;
          idx  = {{SEL_W{1'b0}}, off};
        end
      end
    end else if (seg_eff == '0) begin
      if (off <= OFF_W'(BASE_LAST)) begin
        kind = K_RAM;
        idx  = {{SEL_W{1'b0}}, off};
      end else begin
        kind = K_HOLE;
      end
    end else if (seg_eff < SEG_W'(POP_SEGS)) begin
      kind = K_RAM;
      idx  = {seg_eff[SEL_W-1:0], off};
    end else begin
      kind = K_HOLE;
    end
  end

endmodule

// File: rtl/dmx_ptr_bank.sv
module dmx_ptr_bank
  import dmx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SP_INIT = 'h6F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [3:0][DATA_W-1:0] regs_o
);

  for (genvar g = 0; g < 4; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL =
      (g == int'(PSEL_SP)) ? DATA_W'(SP_INIT) : '0;

    logic              en;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] q_nxt;

    always_comb begin
      en    = wr_en && (wr_sel == 2'(g));
      q_nxt = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_VAL;
      end else if (en) begin
        q <= q_nxt;
      end
    end

    assign regs_o[g] = q;
  end

  // The segment register moves only on a write addressed to it.
  p_seg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == PSEL_S) |=> $stable(regs_o[3]));

endmodule

// File: rtl/dmx_ram.sv
module dmx_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  // Contents are left undefined at power-up.
  logic [DATA_W-1:0] mem [DEPTH];

  // Read-before-write: a write returns the prior content.
  always_ff @(posedge clk) begin
    if (en) begin
      q <= mem[idx];
      if (we) begin
        mem[idx] <= wdata;
      end
    end
  end

endmodule

// File: rtl/dmx_seg_extender.sv
module dmx_seg_extender
  import dmx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int POP_SEGS  = 4,
  parameter int BASE_LAST = 'h6F,
  parameter int SP_INIT   = 'h6F,
  localparam int ADDR_W   = DATA_W,
  localparam int OFF_W    = ADDR_W - 1,
  localparam int SEL_W    = $clog2(POP_SEGS),
  localparam int IDX_W    = SEL_W + OFF_W,
  localparam int DEPTH    = POP_SEGS << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_stack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_invalid
);

  // Reset: asserted asynchronously, released after two edges.
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // Pointer registers and the current segment.
  logic [3:0][DATA_W-1:0] ptr_regs;
  logic [DATA_W-1:0]      seg_cur;

  assign seg_cur = ptr_regs[PSEL_S];

  // Address decode.
  acc_kind_e         dec_kind;
  logic [IDX_W-1:0]  dec_idx;
  logic [1:0]        dec_psel;

  dmx_decode #(
    .ADDR_W   (ADDR_W),
    .SEG_W    (DATA_W),
    .POP_SEGS (POP_SEGS),
    .BASE_LAST(BASE_LAST)
  ) u_decode (
    .addr   (acc_addr),
    .stack  (acc_stack),
    .seg    (seg_cur),
    .kind   (dec_kind),
    .idx    (dec_idx),
    .ptr_sel(dec_psel)
  );

  // Strobes.
  logic ram_en;
  logic ram_we;
  logic ptr_we;
  logic hit_ptr;
  logic hit_hole;

  always_comb begin
    ram_en   = acc_valid && (dec_kind == K_RAM);
    ram_we   = ram_en && acc_write;
    hit_ptr  = acc_valid && (dec_kind == K_PTR);
    ptr_we   = hit_ptr && acc_write;
    hit_hole = acc_valid && (dec_kind == K_HOLE);
  end

  dmx_ptr_bank #(
    .DATA_W (DATA_W),
    .SP_INIT(SP_INIT)
  ) u_ptr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (ptr_we),
    .wr_sel (dec_psel),
    .wr_data(acc_wdata),
    .regs_o (ptr_regs)
  );

  logic [DATA_W-1:0] ram_q;

  dmx_ram #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .idx  (dec_idx),
    .wdata(acc_wdata),
    .q    (ram_q)
  );

  // Response registers: next-state logic.
  acc_kind_e         kind_q,  kind_nxt;
  logic [DATA_W-1:0] ptr_q,   ptr_nxt;
  logic              inv_q,   inv_nxt;
  logic              rsp_en;

  always_comb begin
    rsp_en   = acc_valid;
    kind_nxt = dec_kind;
    ptr_nxt  = hit_ptr ? ptr_regs[dec_psel] : ptr_q;
    inv_nxt  = hit_hole;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      kind_q <= K_FOREIGN;
      ptr_q  <= '0;
      inv_q  <= 1'b0;
    end else begin
      inv_q <= inv_nxt;
      if (rsp_en) begin
        kind_q <= kind_nxt;
        ptr_q  <= ptr_nxt;
      end
    end
  end

  always_comb begin
    case (kind_q)
      K_RAM:   rd_data = ram_q;
      K_PTR:   rd_data = ptr_q;
      default: rd_data = '0;
    endcase
    rd_invalid = inv_q;
  end

  // Upper half never counts as unpopulated.
  p_upper_never_hole_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_addr[ADDR_W-1]) |-> (dec_kind != K_HOLE));

  // Stack-relative lower accesses resolve into segment 0.
  p_stack_base_seg_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_stack && !acc_addr[ADDR_W-1] && dec_kind == K_RAM)
      |-> (dec_idx[IDX_W-1:OFF_W] == '0));

  // An invalid response always carries zero data.
  p_invalid_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_invalid |-> (rd_data == '0));

  // The four unused slots behind the pointer addresses are never written.
  p_ram_slot_guard_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_we |-> !((dec_idx[IDX_W-1:OFF_W] == '0) && (&dec_idx[OFF_W-1:2])));

  // A segment write is visible on the following cycle.
  p_seg_update_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_write && acc_addr == {ADDR_W{1'b1}})
      |=> (seg_cur == $past(acc_wdata)));

endmodule

// File: tb/sim_dmx_seg_extender.sv
module sim_dmx_seg_extender;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_valid;
  logic       acc_write;
  logic [7:0] acc_addr;
  logic [7:0] acc_wdata;
  logic       acc_stack;
  logic [7:0] rd_data;
  logic       rd_invalid;

  always #5 clk = ~clk;

  dmx_seg_extender u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_stack (acc_stack),
    .rd_data   (rd_data),
    .rd_invalid(rd_invalid)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [7:0] data;
    bit         known;
    bit         inv;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] mdl [int];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic int cur_seg();
    return int'(mdl[255]);
  endfunction

  // Physical location from the address map rules.
  function automatic int phys(input logic [7:0] a, input bit stk);
    int s;
    s = stk ? 0 : cur_seg();
    if (a[7]) return int'(a);
    return s * 256 + int'(a[6:0]);
  endfunction

  // 0 = storage, 1 = unpopulated, 2 = upper base I/O space
  function automatic int cls(input int p);
    int lo, sg;
    lo = p % 256;
    sg = p / 256;
    if (sg == 0) begin
      if (lo <= 'h6F || lo >= 'hF0) return 0;
      if (lo >= 'h80) return 2;
      return 1;
    end
    if (sg <= 3) return 0;
    return 1;
  endfunction

  // Driver: predicts the response and presents the access.
  task automatic acc(input bit wr, input bit stk, input logic [7:0] a,
                     input logic [7:0] wd, input string tag);
    exp_t e;
    int p, c;
    @(negedge clk);
    p = phys(a, stk);
    c = cls(p);
    e.tag = tag;
    e.inv = (c == 1);
    if (c == 0) begin
      e.known = mdl.exists(p);
      e.data  = e.known ? mdl[p] : 8'h00;
      if (wr) mdl[p] = wd;
    end else begin
      e.known = 1;
      e.data  = 8'h00;
    end
    sb.push_back(e);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_stack = stk;
    acc_addr  = a;
    acc_wdata = wd;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
    acc_stack = 1'b0;
  endtask

  // Monitor: compares each response one cycle after its access.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (acc_valid === 1'b1) begin
        #2;
        if (sb.size() == 0) begin
          check(1'b0, "R9", "unexpected response", rd_data, 8'h00);
        end else begin
          e = sb.pop_front();
          check(rd_invalid === e.inv, e.tag, "invalid flag",
                {7'd0, rd_invalid}, {7'd0, e.inv});
          if (e.known)
            check(rd_data === e.data, e.tag, "read data", rd_data, e.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired actual 0 expected 1");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    rst_n     = 1'b0;
    acc_valid = 1'b0;
    acc_write = 1'b0;
    acc_stack = 1'b0;
    acc_addr  = 8'h00;
    acc_wdata = 8'h00;
    mdl[252] = 8'h00;
    mdl[253] = 8'h6F;
    mdl[254] = 8'h00;
    mdl[255] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R7: reset state of the response outputs
    check(rd_data === 8'h00, "R7", "reset read data", rd_data, 8'h00);
    check(rd_invalid === 1'b0, "R7", "reset invalid", {7'd0, rd_invalid}, 8'h00);

    // R7: pointer reset values
    acc(0, 0, 8'hFD, 8'h00, "R7");
    acc(0, 0, 8'hFF, 8'h00, "R7");
    acc(0, 0, 8'hFC, 8'h00, "R7");
    acc(0, 0, 8'hFE, 8'h00, "R7");

    // R2 / R8: one location per segment, switching S back to back
    acc(1, 0, 8'h10, 8'hA0, "R10");
    acc(0, 0, 8'h10, 8'h00, "R2");
    acc(1, 0, 8'hFF, 8'h01, "R8");
    acc(1, 0, 8'h10, 8'hB1, "R8");
    acc(1, 0, 8'hFF, 8'h02, "R8");
    acc(1, 0, 8'h10, 8'hC2, "R8");
    acc(1, 0, 8'hFF, 8'h03, "R8");
    acc(1, 0, 8'h10, 8'hD3, "R8");
    acc(0, 0, 8'h10, 8'h00, "R2");
    acc(1, 0, 8'hFF, 8'h01, "R8");
    acc(0, 0, 8'h10, 8'h00, "R2");
    acc(1, 0, 8'h10, 8'hB7, "R10");
    acc(0, 0, 8'h10, 8'h00, "R10");

    // R3: stack accesses pinned to segment 0, S untouched
    acc(1, 0, 8'hFF, 8'h03, "R3");
    acc(0, 1, 8'h10, 8'h00, "R3");
    acc(1, 1, 8'h20, 8'h55, "R3");
    acc(0, 0, 8'hFF, 8'h00, "R3");
    acc(0, 0, 8'h20, 8'h00, "R3");
    acc(1, 0, 8'hFF, 8'h00, "R3");
    acc(0, 0, 8'h20, 8'h00, "R3");

    // R1: register window independent of S and the stack flag
    acc(1, 0, 8'hFF, 8'h02, "R1");
    acc(1, 0, 8'hF3, 8'h77, "R1");
    acc(1, 0, 8'hFF, 8'h09, "R1");
    acc(0, 0, 8'hF3, 8'h00, "R1");
    acc(0, 1, 8'hF3, 8'h00, "R1");
    acc(1, 0, 8'hFB, 8'h3C, "R1");
    acc(0, 0, 8'hFB, 8'h00, "R1");

    // R11: upper base I/O space
    acc(0, 0, 8'h85, 8'h00, "R11");
    acc(1, 0, 8'hEF, 8'h99, "R11");
    acc(0, 0, 8'hEF, 8'h00, "R11");

    // R4: hole in segment 0, valid edge at 0x6F
    acc(1, 0, 8'hFF, 8'h00, "R4");
    acc(1, 0, 8'h6F, 8'h42, "R4");
    acc(0, 0, 8'h6F, 8'h00, "R4");
    acc(1, 0, 8'h75, 8'h99, "R4");
    acc(0, 0, 8'h75, 8'h00, "R4");
    acc(1, 0, 8'h70, 8'h98, "R4");
    acc(0, 0, 8'hF0, 8'h00, "R4");
    acc(1, 0, 8'hFF, 8'h01, "R4");
    acc(0, 1, 8'h7F, 8'h00, "R4");
    idle();
    @(negedge clk);
    check(rd_invalid === 1'b0, "R9", "invalid after idle", {7'd0, rd_invalid}, 8'h00);

    // R5: unpopulated segments, writes must not land anywhere
    acc(1, 0, 8'hFF, 8'h04, "R5");
    acc(0, 0, 8'h10, 8'h00, "R5");
    acc(1, 0, 8'h10, 8'hEE, "R5");
    acc(1, 0, 8'hFF, 8'hFF, "R5");
    acc(1, 0, 8'h10, 8'hEF, "R5");
    acc(1, 0, 8'hFF, 8'h00, "R5");
    acc(0, 0, 8'h10, 8'h00, "R5");
    acc(1, 0, 8'hFF, 8'h02, "R5");
    acc(0, 0, 8'h10, 8'h00, "R5");
    acc(1, 0, 8'hFF, 8'h03, "R5");
    acc(0, 0, 8'h10, 8'h00, "R5");
    acc(1, 0, 8'h7F, 8'h5A, "R5");
    acc(0, 0, 8'h7F, 8'h00, "R5");

    // R6: pointer registers
    acc(1, 0, 8'hFC, 8'h12, "R6");
    acc(1, 0, 8'hFD, 8'h34, "R6");
    acc(1, 0, 8'hFE, 8'h56, "R6");
    acc(0, 0, 8'hFC, 8'h00, "R6");
    acc(0, 0, 8'hFD, 8'h00, "R6");
    acc(0, 0, 8'hFE, 8'h00, "R6");
    acc(0, 0, 8'hFF, 8'h00, "R6");

    // R2: pseudo-random mix, including stray segment values
    r = 32'h1D2C_3B4A;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      r = r ^ (r << 13);
      r = r ^ (r >> 17);
      r = r ^ (r << 5);
      case (r[3:2])
        2'd0:    a = {1'b0, r[10:4]};
        2'd1:    a = {4'hF, r[7:4]};
        2'd2:    a = r[12] ? 8'hFF : {1'b0, 3'b110, r[7:4]};
        default: a = {1'b0, 2'b11, r[8:4]};
      endcase
      if (a == 8'hFF) acc(r[0], r[1], a, {6'd0, r[15:14]} + (r[20] ? 8'h04 : 8'h00), "R2");
      else            acc(r[0], r[1], a, r[23:16], "R2");
    end

    idle();
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R9", "pending responses", 8'(sb.size()), 8'h00);
    finish_run();
  end

endmodule